// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the combinational arithmetic and logic stage of a small RISC controller. Each evaluation takes two data operands, a 5-bit operation code and the current 8-bit status word. From these it returns an 8-bit result, a 16-bit product and the next status word. There is no clock inside the block. The result and the status settle in the same cycle that the operands and the operation code are applied.

Each operation may rewrite only a fixed subset of the status bits. Every other bit leaves the block exactly as it arrived. The instruction decoder supplies the operation code and writes the result back to the register file, and neither task is part of this block. The multiply delivers its product as a high byte and a low byte, so the surrounding datapath can store them in a register pair.

Status bit positions, from bit 7 down to bit 0: interrupt enable, bit-transfer, half carry H, sign S, overflow V, negative N, zero Z, carry C.

Top module: `alu8_core`

## Requirements
- R1: Status bits 7 and 6 always leave the block equal to their input values. Applying op 0 with both operands 0 and status 0 gives result 0 and status 0x02.
- R2: Op 0 computes a+b and op 1 computes a+b+C. C is the carry out of bit 7, H is the carry from bit 3 into bit 4, and V is signed overflow. Both ops may change H, S, V, N, Z and C.
- R3: Op 2 computes a-b and op 3 computes a-b-C. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. Both ops may change H, S, V, N, Z and C.
- R4: Whenever an op may change N or V, S equals N xor V and N equals result bit 7. Z is 1 exactly when the 8-bit result is zero, except for op 18.
- R5: Op 4 gives AND, op 5 gives OR, op 6 gives XOR and op 11 gives clear to 0x00. Each of these forces V to 0 and may change only Z, N, V and S, so C and H are preserved.
- R6: Op 7 gives the one's complement and sets C to 1 and V to 0. Op 8 gives the two's complement (0-a). For op 8, C is 1 unless the result is zero, V is 1 only for input 0x80, and H is the borrow out of bit 3.
- R7: Op 9 gives a+1 and op 10 gives a-1. V is set only for input 0x7F on op 9 and only for input 0x80 on op 10. C and H are preserved.
- R8: Op 13 shifts left with 0 into bit 0 and op 14 shifts right with 0 into bit 7. Op 15 shifts right while keeping bit 7. Op 16 rotates left, taking the old C into bit 0. C receives the bit shifted out, and V equals N xor C.
- R9: Op 12 gives 0xFF and op 17 swaps the nibbles of a. Neither changes any status bit.
- R10: Op 18 outputs the unsigned product a*b on product[15:0] and its low byte on result. C equals product bit 15, Z is 1 exactly when the full product is zero, and no other status bit changes. For every other op, product is zero.
- R11: Op 19 sets C and op 20 clears C. Neither changes any other status bit, and the result equals operand a.
- R12: Op codes 21 to 31 return operand a with the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand (destination side) |
| opnd_b | input | 8 | Second operand (source side) |
| op_sel | input | 5 | Operation code |
| stat_in | input | 8 | Current status word |
| result | output | 8 | Operation result |
| product | output | 16 | Multiply product, zero unless op 18 |
| stat_out | output | 8 | Next status word |

## Verification
The bench aims at the half-carry and borrow boundaries at 0x0F/0x10. These catch a design that takes H from the wrong bit or inverts the borrow sense. It also drives signed-overflow edges at 0x7F and 0x80 through add, increment, decrement and negate, since a wrong V would then disagree with S. Several cases arrive with C and H already set, so that logic, increment and clear operations show whether a design clobbers flags that lie outside their mask. Multiply cases include 0xFF*0xFF, which sets product bit 15 and so C. A sweep over all 32 codes with varied status words exposes unassigned codes that disturb the status and shifts whose V is not N xor C.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes, status bit positions and the per-op
// mask of status bits each operation may rewrite.
package alu8_pkg;

    localparam int STAT_W = 8;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
        OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_CLR  = 5'd11,
        OP_SER  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ASR  = 5'd15,
        OP_ROL  = 5'd16, OP_SWAP = 5'd17, OP_MUL  = 5'd18, OP_SEC  = 5'd19,
        OP_CLC  = 5'd20
    } alu_op_e;

    // Which status bits an operation is allowed to change.
    function automatic logic [STAT_W-1:0] flag_mask(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: flag_mask = 8'h3F;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_CLR: flag_mask = 8'h1E;
            OP_COM, OP_LSL, OP_LSR, OP_ASR, OP_ROL: flag_mask = 8'h1F;
            OP_MUL:         flag_mask = 8'h03;
            OP_SEC, OP_CLC: flag_mask = 8'h01;
            default:        flag_mask = 8'h00;
        endcase
    endfunction

    // True for operations whose result comes from the add/subtract path.
    function automatic logic uses_adder(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: uses_adder = 1'b1;
            default: uses_adder = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
// Module: shared adder/subtractor. Produces the sum or difference with the
// carry (or borrow) out of the top bit, the carry (or borrow) out of the
// low half, and signed overflow. Assumes W is even.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half,
    output logic         ovf
);
    localparam int HB = W / 2;

    logic [W:0]  wide;
    logic [HB:0] low;

    // Purpose: full-width and low-half add or subtract with carry-in.
    always_comb begin
        if (sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            low  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin};
            ovf  = (x[W-1] != y[W-1]) && (wide[W-1] != x[W-1]);
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
            ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
        end
    end

    assign sum   = wide[W-1:0];
    assign carry = wide[W];
    assign half  = low[HB];

    // Purpose: sanity of the carry and borrow outputs against the operands.
    always_comb begin
        if (!sub && !carry)
            AST_ADD_NO_WRAP: assert (sum >= x); // R2
        if (sub && !carry)
            AST_SUB_NO_WRAP: assert (sum <= x); // R3
    end

endmodule

// File: rtl/alu8_bitops.sv
// Module: logic, constant, shift, rotate and nibble-swap results, plus the
// bit shifted out by a shift or rotate. Any other op passes operand a.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         sh_c
);
    localparam int HB = W / 2;

    // Purpose: select the bitwise or positional result for the operation.
    always_comb begin
        sh_c = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_CLR:  res = '0;
            OP_SER:  res = '1;
            OP_LSL:  begin res = {a[W-2:0], 1'b0};     sh_c = a[W-1]; end
            OP_LSR:  begin res = {1'b0, a[W-1:1]};     sh_c = a[0];   end
            OP_ASR:  begin res = {a[W-1], a[W-1:1]};   sh_c = a[0];   end
            OP_ROL:  begin res = {a[W-2:0], cin};      sh_c = a[W-1]; end
            OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
            default: res = a;
        endcase
    end

    // Purpose: check the sign-keeping shift and the rotate carry-in.
    always_comb begin
        if (op == OP_ASR)
            AST_ASR_KEEPS_SIGN: assert (res[W-1] == a[W-1]); // R8
        if (op == OP_ROL)
            AST_ROL_TAKES_C: assert (res[0] == cin); // R8
    end

endmodule

// File: rtl/alu8_mul.sv
// Module: unsigned W x W multiplier whose output is held at zero unless
// enabled, so downstream storage sees a quiet bus on other operations.
module alu8_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           en,
    output logic [2*W-1:0] product
);
    // Purpose: gated full-width product.
    always_comb begin
        if (en)
            product = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        else
            product = '0;
    end

    // Purpose: identity check on a unit multiplier.
    always_comb begin
        if (en && b == {{(W-1){1'b0}}, 1'b1})
            AST_MUL_BY_ONE: assert (product == {{W{1'b0}}, a}); // R10
    end

endmodule

// File: rtl/alu8_flags.sv
// Module: builds candidate status bits for the operation, then merges
// them with the incoming status through the operation's write mask.
// Assumes an 8-bit status word with the bit positions of the package.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      res,
    input  logic              ar_c,
    input  logic              ar_h,
    input  logic              ar_v,
    input  logic              sh_c,
    input  logic [2*W-1:0]    product,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_out
);
    logic [STAT_W-1:0] cand;
    logic [STAT_W-1:0] mask;

    assign mask = flag_mask(op);

    // Purpose: compute every flag the operation could produce.
    always_comb begin
        cand       = stat_in;
        cand[FL_Z] = (res == '0);
        cand[FL_N] = res[W-1];
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: begin
                cand[FL_C] = ar_c;
                cand[FL_H] = ar_h;
                cand[FL_V] = ar_v;
            end
            OP_AND, OP_OR, OP_XOR, OP_CLR: cand[FL_V] = 1'b0;
            OP_COM: begin
                cand[FL_V] = 1'b0;
                cand[FL_C] = 1'b1;
            end
            OP_LSL, OP_LSR, OP_ASR, OP_ROL: begin
                cand[FL_C] = sh_c;
                cand[FL_V] = res[W-1] ^ sh_c;
            end
            OP_MUL: begin
                cand[FL_C] = product[2*W-1];
                cand[FL_Z] = (product == '0);
            end
            OP_SEC:  cand[FL_C] = 1'b1;
            OP_CLC:  cand[FL_C] = 1'b0;
            default: cand = stat_in;
        endcase
        cand[FL_S] = cand[FL_N] ^ cand[FL_V];
    end

    // Purpose: apply only the bits the operation is allowed to write.
    assign stat_out = (cand & mask) | (stat_in & ~mask);

    // Purpose: check fixed flag outcomes of complement and clear.
    always_comb begin
        if (op == OP_COM)
            AST_COM_SETS_C: assert (stat_out[FL_C] && !stat_out[FL_V]); // R6
        if (op == OP_CLR)
            AST_CLR_FLAGS: assert (stat_out[FL_Z] && !stat_out[FL_N]
                                   && stat_out[FL_C] == stat_in[FL_C]); // R5
    end

endmodule

// File: rtl/alu8_core.sv
// Module: top of the combinational ALU. Routes operands to the shared
// adder, the bitwise/shift unit and the multiplier, selects the result,
// and derives the next status word. Assumes op_sel is valid for the
// whole cycle; unassigned codes pass operand a and keep the status.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [4:0]        op_sel,
    input  logic [STAT_W-1:0] stat_in,
    output logic [W-1:0]      result,
    output logic [2*W-1:0]    product,
    output logic [STAT_W-1:0] stat_out
);
    alu_op_e      op_e;
    logic [W-1:0] ax, ay, sum, bit_res;
    logic         ci, sb, ar_c, ar_h, ar_v, sh_c;

    assign op_e = alu_op_e'(op_sel);

    // Purpose: choose adder operands, carry-in and direction per operation.
    always_comb begin
        ax = opnd_a;
        ay = opnd_b;
        ci = 1'b0;
        sb = 1'b0;
        case (op_e)
            OP_ADC: ci = stat_in[FL_C];
            OP_SUB: sb = 1'b1;
            OP_SBC: begin sb = 1'b1; ci = stat_in[FL_C]; end
            OP_NEG: begin ax = '0; ay = opnd_a; sb = 1'b1; end
            OP_INC: ay = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin ay = {{(W-1){1'b0}}, 1'b1}; sb = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x(ax), .y(ay), .cin(ci), .sub(sb),
        .sum(sum), .carry(ar_c), .half(ar_h), .ovf(ar_v)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op(op_e), .a(opnd_a), .b(opnd_b), .cin(stat_in[FL_C]),
        .res(bit_res), .sh_c(sh_c)
    );

    alu8_mul #(.W(W)) u_mul (
        .a(opnd_a), .b(opnd_b), .en(op_e == OP_MUL), .product(product)
    );

    // Purpose: final result selection.
    always_comb begin
        if (uses_adder(op_e))
            result = sum;
        else if (op_e == OP_MUL)
            result = product[W-1:0];
        else
            result = bit_res;
    end

    alu8_flags #(.W(W)) u_flags (
        .op(op_e), .res(result), .ar_c(ar_c), .ar_h(ar_h), .ar_v(ar_v),
        .sh_c(sh_c), .product(product), .stat_in(stat_in), .stat_out(stat_out)
    );

    // Purpose: port-level status relations.
    always_comb begin
        AST_TOP_BITS_KEPT: assert (stat_out[FL_I:FL_T] == stat_in[FL_I:FL_T]); // R1
        if (flag_mask(op_e)[FL_N])
            AST_SIGN_IS_N_XOR_V: assert (stat_out[FL_S] == (stat_out[FL_N] ^ stat_out[FL_V])); // R4
        if (flag_mask(op_e)[FL_Z] && op_e != OP_MUL)
            AST_ZERO_MATCHES: assert (stat_out[FL_Z] == (result == '0)); // R4
        if (op_e == OP_MUL)
            AST_MUL_CARRY_TOP: assert (stat_out[FL_C] == product[2*W-1]); // R10
        else
            AST_PRODUCT_QUIET: assert (product == '0); // R10
    end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    typedef struct {
        string       tag;
        int          op;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic [7:0]  a = '0, b = '0, s = '0;
    logic [4:0]  op = '0;
    logic [7:0]  result, stat_out;
    logic [15:0] product;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;
    item_t       sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu8_core u0 (
        .opnd_a(a), .opnd_b(b), .op_sel(op), .stat_in(s),
        .result(result), .product(product), .stat_out(stat_out)
    );

    // Expected {result, product, status} from the requirement text.
    function automatic logic [31:0] model(input int o, input logic [7:0] x,
                                          input logic [7:0] y, input logic [7:0] st);
        logic [7:0] r, m, f;
        logic [15:0] p;
        logic [8:0] t;
        logic [4:0] h;
        logic cin;
        f = st; p = '0; r = x; m = '0;
        cin = (o == 1 || o == 3) ? st[0] : 1'b0;
        case (o)
            0, 1: begin
                t = {1'b0, x} + {1'b0, y} + {8'b0, cin};
                h = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, cin};
                r = t[7:0]; f[0] = t[8]; f[5] = h[4];
                f[3] = (x[7] == y[7]) && (r[7] != x[7]); m = 8'h3F;
            end
            2, 3: begin
                t = {1'b0, x} - {1'b0, y} - {8'b0, cin};
                h = {1'b0, x[3:0]} - {1'b0, y[3:0]} - {4'b0, cin};
                r = t[7:0]; f[0] = t[8]; f[5] = h[4];
                f[3] = (x[7] != y[7]) && (r[7] != x[7]); m = 8'h3F;
            end
            4: begin r = x & y; f[3] = 1'b0; m = 8'h1E; end
            5: begin r = x | y; f[3] = 1'b0; m = 8'h1E; end
            6: begin r = x ^ y; f[3] = 1'b0; m = 8'h1E; end
            7: begin r = ~x; f[0] = 1'b1; f[3] = 1'b0; m = 8'h1F; end
            8: begin
                r = 8'(0 - x); f[0] = (r != 0); f[3] = (x == 8'h80);
                f[5] = (x[3:0] != 0); m = 8'h3F;
            end
            9:  begin r = x + 8'd1; f[3] = (x == 8'h7F); m = 8'h1E; end
            10: begin r = x - 8'd1; f[3] = (x == 8'h80); m = 8'h1E; end
            11: begin r = 8'h00; f[3] = 1'b0; m = 8'h1E; end
            12: r = 8'hFF;
            13: begin r = {x[6:0], 1'b0};  f[0] = x[7]; f[3] = r[7] ^ f[0]; m = 8'h1F; end
            14: begin r = {1'b0, x[7:1]};  f[0] = x[0]; f[3] = r[7] ^ f[0]; m = 8'h1F; end
            15: begin r = {x[7], x[7:1]};  f[0] = x[0]; f[3] = r[7] ^ f[0]; m = 8'h1F; end
            16: begin r = {x[6:0], st[0]}; f[0] = x[7]; f[3] = r[7] ^ f[0]; m = 8'h1F; end
            17: r = {x[3:0], x[7:4]};
            18: begin
                p = {8'b0, x} * {8'b0, y}; r = p[7:0];
                f[0] = p[15]; f[1] = (p == 0); m = 8'h03;
            end
            19: begin f[0] = 1'b1; m = 8'h01; end
            20: begin f[0] = 1'b0; m = 8'h01; end
            default: ;
        endcase
        f[2] = r[7];
        if (o != 18) f[1] = (r == 0);
        f[4] = f[2] ^ f[3];
        f = (f & m) | (st & ~m);
        return {r, p, f};
    endfunction

    // Driver: apply one vector and queue its expected outputs.
    task automatic drive(input string tag, input int o, input logic [7:0] x,
                         input logic [7:0] y, input logic [7:0] st);
        item_t it;
        @(posedge clk);
        op = 5'(o); a = x; b = y; s = st;
        it.tag = tag; it.op = o; it.exp = model(o, x, y, st);
        sb_q.push_back(it);
    endtask

    // Monitor: compare settled outputs away from the driving edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = {result, product, stat_out};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s op=%0d a=%h b=%h s=%h actual=%h expected=%h",
                         it.tag, it.op, a, b, s, act, it.exp);
            end
        end
    end

    initial begin
        drive("R1 idle", 0, 8'h00, 8'h00, 8'h00);
        drive("R1 top bits", 0, 8'h15, 8'h25, 8'hC0);
        drive("R2 add", 0, 8'h15, 8'h25, 8'h00);
        drive("R2 half", 0, 8'h0F, 8'h01, 8'h00);
        drive("R2 ovf", 0, 8'h7F, 8'h01, 8'h00);
        drive("R2 carry", 0, 8'hFF, 8'h01, 8'h00);
        drive("R2 adc", 1, 8'h15, 8'h25, 8'h01);
        drive("R3 half", 2, 8'h10, 8'h01, 8'h00);
        drive("R3 borrow", 2, 8'h00, 8'h01, 8'h00);
        drive("R3 sbc", 3, 8'h25, 8'h15, 8'h01);
        drive("R3 ovf", 2, 8'h80, 8'h01, 8'h00);
        drive("R5 and", 4, 8'h53, 8'hF0, 8'h21);
        drive("R5 or", 5, 8'h43, 8'h10, 8'h29);
        drive("R5 xor", 6, 8'hD3, 8'hAA, 8'h08);
        drive("R5 clr", 11, 8'h55, 8'h00, 8'hFF);
        drive("R6 com", 7, 8'h55, 8'h00, 8'h00);
        drive("R6 neg", 8, 8'h55, 8'h00, 8'h00);
        drive("R6 neg zero", 8, 8'h00, 8'h00, 8'h21);
        drive("R6 neg 80", 8, 8'h80, 8'h00, 8'h00);
        drive("R7 inc", 9, 8'h7F, 8'h00, 8'h21);
        drive("R7 dec", 10, 8'h80, 8'h00, 8'h21);
        drive("R7 inc wrap", 9, 8'hFF, 8'h00, 8'h00);
        drive("R8 lsl", 13, 8'h8D, 8'h00, 8'h00);
        drive("R8 lsr", 14, 8'h8D, 8'h00, 8'h00);
        drive("R8 asr", 15, 8'h8D, 8'h00, 8'h00);
        drive("R8 rol", 16, 8'h0D, 8'h00, 8'h01);
        drive("R9 swap", 17, 8'hF0, 8'h00, 8'hA5);
        drive("R9 ser", 12, 8'h55, 8'h00, 8'h5A);
        drive("R10 mul", 18, 8'h15, 8'h25, 8'h3C);
        drive("R10 mul top", 18, 8'hFF, 8'hFF, 8'h00);
        drive("R10 mul zero", 18, 8'h00, 8'h37, 8'h00);
        drive("R11 sec", 19, 8'h33, 8'h00, 8'h00);
        drive("R11 clc", 20, 8'h33, 8'h00, 8'hFF);
        drive("R12 unused", 25, 8'h6E, 8'h11, 8'hB7);
        for (int o = 0; o < 32; o++) begin
            for (int k = 0; k < 8; k++) begin
                drive("R4 sweep", o, 8'(o * 37 + k * 91 + 3),
                      8'(k * 53 + o * 11 + 128), 8'(k * 29 + o * 7));
            end
        end
        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule